// File: doc/BRIEF.md
# Carry-Save Maximum/Minimum Selector

The block takes two operands held in carry-save form and returns the larger of the two, or the smaller when its mode input asks for it. Each operand is a W-digit word. Digit j carries a carry bit and a sum bit, so the digit value is c[j]+s[j], which is 0, 1 or 2, and its weight is 2^j. The result stays in carry-save form, so a downstream add-compare loop can use it without a carry-propagate adder.

The comparison starts at the most significant digit and moves one digit level per pipeline stage. At each level a five-state decision (equal, A decided, B decided, A tentatively ahead, B tentatively ahead) is updated from the difference of the two current digits. The output digit for that level is taken from the branch that currently leads, before the lower digits have been examined. The inputs are skewed and the outputs deskewed, so a new operand pair can enter on every clock. Each result appears W clock edges after the edge that captured its operands.

Minimum selection reuses the same datapath. Both inputs are bit-inverted, which maps digit value v to 2-v. The maximum is then selected and the result is inverted back. A select indicator reports which operand won.

Top module: `csmax_select`

## Requirements
- R1: While rstN is low, gC, gS and pickB are 0. After release, the outputs stay 0 until the first operand pair has crossed the pipeline.
- R2: With selMin=0, the value sum over j of (gC[j]+gS[j])*2^j equals the larger of the two operand values. It appears at the outputs W rising edges after the edge that captured the operands.
- R3: With selMin=1 and the same latency, the output value equals the smaller of the two operand values.
- R4: pickB is 1 when B is strictly larger (selMin=0) or strictly smaller (selMin=1). When the values are equal, pickB is 0, whatever digit codes were used.
- R5: In maximum mode, no output digit uses the code c=1,s=0. In minimum mode, no output digit uses the code c=0,s=1.
- R6: When both operands have identical bits, the output repeats them digit by digit. Values 0 and 2 appear as c=0,s=0 and c=1,s=1. Value 1 appears as c=0,s=1 in maximum mode and as c=1,s=0 in minimum mode.
- R7: A new operand pair, each with its own selMin value, is accepted on every clock edge, and results come out in order.
- R8: Once a level finds a digit difference that the lower digits cannot overcome, that choice holds. Example: A has a 2 in the top digit and 0 elsewhere; B has 0 in the top digit and 2 in every other digit. A wins.
- R9: A tentative lead cancelled by an opposite difference of 2 at the next digit returns the comparison to equal. Lower digits then decide the result, and the output value is still exact.
- R10: A tentative lead that only decreases by 1 at each lower digit stays undecided down to the least significant digit. Example: top digit 1 against all lower digits 1 means the first operand wins by exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selMin | input | 1 | 0 selects the maximum, 1 selects the minimum |
| aC | input | W | Carry bits of operand A |
| aS | input | W | Sum bits of operand A |
| bC | input | W | Carry bits of operand B |
| bS | input | W | Sum bits of operand B |
| gC | output | W | Carry bits of the selected result |
| gS | output | W | Sum bits of the selected result |
| pickB | output | 1 | 1 when operand B was selected |

## Verification
The assertions allow all four digit codes on both operands, including the redundant c=1,s=0 form, and they place no limit on how often selMin changes. The stage-to-stage checks assume that the top level always starts in the equal state. The identical-operand check relies on exact bit equality of the raw inputs. The stimulus therefore mixes fully random operand pairs with exact copies, copies recoded between the two forms of digit value 1, and copies with a single digit changed. Directed words drive tentative leads that persist, that cancel, and that are overturned at the least significant digit, in both modes.

// File: rtl/csmax_pkg.sv
package csmax_pkg;

  typedef enum logic [2:0] {
    CMP_EQ   = 3'd0,
    CMP_AFIN = 3'd1,
    CMP_BFIN = 3'd2,
    CMP_APRE = 3'd3,
    CMP_BPRE = 3'd4
  } cmpState_t;

  // Per-level strobes from control to datapath
  typedef struct packed {
    logic enA;
    logic enB;
  } digitSel_t;

  // Canonical form: value 1 always as c=0,s=1. Bit order {c,s}.
  function automatic logic [1:0] suppressDigit(input logic [1:0] cs);
    return {cs[1] & cs[0], cs[1] | cs[0]};
  endfunction

  function automatic logic signed [2:0] digitDiff(input logic [1:0] da, input logic [1:0] db);
    logic [1:0] va;
    logic [1:0] vb;
    va = {da[1] & da[0], da[1] ^ da[0]};
    vb = {db[1] & db[0], db[1] ^ db[0]};
    return $signed({1'b0, va}) - $signed({1'b0, vb});
  endfunction

  function automatic cmpState_t stepState(input cmpState_t st, input logic signed [2:0] d);
    cmpState_t nx;
    case (st)
      CMP_AFIN, CMP_BFIN: nx = st;
      CMP_APRE: begin
        if (d >= 3'sd0)       nx = CMP_AFIN;
        else if (d == -3'sd1) nx = CMP_APRE;
        else                  nx = CMP_EQ;
      end
      CMP_BPRE: begin
        if (d <= 3'sd0)       nx = CMP_BFIN;
        else if (d == 3'sd1)  nx = CMP_BPRE;
        else                  nx = CMP_EQ;
      end
      default: begin
        if (d == 3'sd2)       nx = CMP_AFIN;
        else if (d == 3'sd1)  nx = CMP_APRE;
        else if (d == -3'sd1) nx = CMP_BPRE;
        else if (d == -3'sd2) nx = CMP_BFIN;
        else                  nx = CMP_EQ;
      end
    endcase
    return nx;
  endfunction

  // Leader: branch whose prefix has been emitted (1 = B). Kept across ties.
  function automatic logic leadStep(input cmpState_t post, input logic lead);
    logic nx;
    case (post)
      CMP_AFIN, CMP_APRE: nx = 1'b0;
      CMP_BFIN, CMP_BPRE: nx = 1'b1;
      default:            nx = lead;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/csmax_delay.sv
module csmax_delay #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] tap [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
    end else begin
      tap[0] <= din;
      for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
    end
  end

  assign dout = tap[DEPTH-1];

endmodule

// File: rtl/csmax_datapath.sv
module csmax_datapath
  import csmax_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           selMin,
  input  logic [W-1:0]   aC,
  input  logic [W-1:0]   aS,
  input  logic [W-1:0]   bC,
  input  logic [W-1:0]   bS,
  input  digitSel_t      sel [W],
  output logic [1:0]     levA [W],
  output logic [1:0]     levB [W],
  output logic [W-1:0]   gC,
  output logic [W-1:0]   gS,
  output logic           outMin
);

  localparam int LAT = W;

  logic [W-1:0]   aCi, aSi, bCi, bSi;
  logic [LAT-1:0] modePipe;
  logic [1:0]     outDig [W];

  // Minimum selection: invert on entry (value v -> 2-v), invert again on exit
  assign aCi = aC ^ {W{selMin}};
  assign aSi = aS ^ {W{selMin}};
  assign bCi = bC ^ {W{selMin}};
  assign bSi = bS ^ {W{selMin}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modePipe <= '0;
    else       modePipe <= {modePipe[LAT-2:0], selMin};
  end

  assign outMin = modePipe[LAT-1];

  for (genvar k = 0; k < W; k++) begin : g_level
    localparam int J = W - 1 - k;
    logic [3:0] rawPair;
    logic [3:0] levPair;
    logic [1:0] chosen;
    logic [1:0] pickDig;

    assign rawPair = {suppressDigit({aCi[J], aSi[J]}), suppressDigit({bCi[J], bSi[J]})};

    // Input skew: level k sees its digit k cycles late
    if (k == 0) begin : g_noskew
      assign levPair = rawPair;
    end else begin : g_skew
      csmax_delay #(.WIDTH(4), .DEPTH(k)) u_skew (
        .clk (clk),
        .rstN(rstN),
        .din (rawPair),
        .dout(levPair)
      );
    end

    assign levA[k] = levPair[3:2];
    assign levB[k] = levPair[1:0];

    assign chosen = ({2{sel[k].enA}} & levA[k]) | ({2{sel[k].enB}} & levB[k]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pickDig <= '0;
      else       pickDig <= chosen;
    end

    // Output deskew: align all digits to the last level
    if (k == W - 1) begin : g_nodeskew
      assign outDig[J] = pickDig;
    end else begin : g_deskew
      csmax_delay #(.WIDTH(2), .DEPTH(W - 1 - k)) u_deskew (
        .clk (clk),
        .rstN(rstN),
        .din (pickDig),
        .dout(outDig[J])
      );
    end

    assign gC[J] = outDig[J][1] ^ outMin;
    assign gS[J] = outDig[J][0] ^ outMin;
  end

endmodule

// File: rtl/csmax_ctrl.sv
module csmax_ctrl
  import csmax_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] levA [W],
  input  logic [1:0] levB [W],
  output digitSel_t  sel [W],
  output cmpState_t  stLevel [W],
  output logic       pickB
);

  logic leadReg [W-1];

  for (genvar k = 0; k < W; k++) begin : g_level
    cmpState_t stIn;
    cmpState_t stPost;
    logic      leadIn;
    logic      leadPost;

    if (k == 0) begin : g_top
      assign stIn   = CMP_EQ;
      assign leadIn = 1'b0;
    end else begin : g_chain
      assign stIn   = stLevel[k-1];
      assign leadIn = leadReg[k-1];
    end

    assign stPost   = stepState(stIn, digitDiff(levA[k], levB[k]));
    assign leadPost = leadStep(stPost, leadIn);

    assign sel[k].enA = ~leadPost;
    assign sel[k].enB = leadPost;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stLevel[k] <= CMP_EQ;
      else       stLevel[k] <= stPost;
    end

    if (k < W - 1) begin : g_lead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) leadReg[k] <= 1'b0;
        else       leadReg[k] <= leadPost;
      end
    end
  end

  // Equal at the end reports A
  assign pickB = (stLevel[W-1] == CMP_BFIN) || (stLevel[W-1] == CMP_BPRE);

endmodule

// File: rtl/csmax_select.sv
module csmax_select
  import csmax_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         selMin,
  input  logic [W-1:0] aC,
  input  logic [W-1:0] aS,
  input  logic [W-1:0] bC,
  input  logic [W-1:0] bS,
  output logic [W-1:0] gC,
  output logic [W-1:0] gS,
  output logic         pickB
);

  digitSel_t  sel [W];
  logic [1:0] levA [W];
  logic [1:0] levB [W];
  cmpState_t  stLevel [W];
  logic       outMin;

  csmax_datapath #(.W(W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .selMin(selMin),
    .aC    (aC),
    .aS    (aS),
    .bC    (bC),
    .bS    (bS),
    .sel   (sel),
    .levA  (levA),
    .levB  (levB),
    .gC    (gC),
    .gS    (gS),
    .outMin(outMin)
  );

  csmax_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .levA   (levA),
    .levB   (levB),
    .sel    (sel),
    .stLevel(stLevel),
    .pickB  (pickB)
  );

endmodule

// File: rtl/csmax_checker.sv
module csmax_checker
  import csmax_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] aC,
  input logic [W-1:0] aS,
  input logic [W-1:0] bC,
  input logic [W-1:0] bS,
  input logic [W-1:0] gC,
  input logic [W-1:0] gS,
  input logic         pickB,
  input logic         outMin,
  input cmpState_t    stLevel [W]
);

  logic [W-1:0] identPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) identPipe <= '0;
    else       identPipe <= {identPipe[W-2:0], (aC == bC) && (aS == bS)};
  end

  // R5
  maxform_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outMin |-> ((gC & ~gS) == '0));

  // R5
  minform_chk: assert property (@(posedge clk) disable iff (!rstN)
    outMin |-> ((~gC & gS) == '0));

  // R4
  ident_chk: assert property (@(posedge clk) disable iff (!rstN)
    identPipe[W-1] |-> !pickB);

  for (genvar k = 1; k < W; k++) begin : g_lvl
    // R8
    afinhold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stLevel[k-1] == CMP_AFIN) |=> (stLevel[k] == CMP_AFIN));
    // R8
    bfinhold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stLevel[k-1] == CMP_BFIN) |=> (stLevel[k] == CMP_BFIN));
    // R9
    aprenoflip_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stLevel[k-1] == CMP_APRE) |=> (stLevel[k] != CMP_BFIN && stLevel[k] != CMP_BPRE));
    // R9
    bprenoflip_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stLevel[k-1] == CMP_BPRE) |=> (stLevel[k] != CMP_AFIN && stLevel[k] != CMP_APRE));
  end

endmodule

bind csmax_select csmax_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .aC     (aC),
  .aS     (aS),
  .bC     (bC),
  .bS     (bS),
  .gC     (gC),
  .gS     (gS),
  .pickB  (pickB),
  .outMin (outMin),
  .stLevel(stLevel)
);

// File: tb/tb_csmax_select.sv
module tb_csmax_select;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         selMin = 1'b0;
  logic [W-1:0] aC = '0, aS = '0, bC = '0, bS = '0;
  logic [W-1:0] gC, gS;
  logic         pickB;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int           qVal[$];
  bit           qPick[$];
  bit           qMin[$];
  bit           qIdent[$];
  logic [W-1:0] qIdC[$];
  logic [W-1:0] qIdS[$];
  string        qTag[$];

  always #4 clk = ~clk;  // 125 MHz

  csmax_select #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .selMin(selMin),
    .aC(aC), .aS(aS), .bC(bC), .bS(bS),
    .gC(gC), .gS(gS), .pickB(pickB)
  );

  function automatic int wordVal(input logic [W-1:0] c, input logic [W-1:0] s);
    int v = 0;
    for (int j = 0; j < W; j++) v += (int'(c[j]) + int'(s[j])) << j;
    return v;
  endfunction

  // vals: 2 bits per digit holding 0..2; alt bit j picks c=1,s=0 for value 1
  function automatic logic [2*W-1:0] enc(input logic [2*W-1:0] vals, input logic [W-1:0] alt);
    logic [W-1:0] c, s;
    for (int j = 0; j < W; j++) begin
      case (vals[2*j +: 2])
        2'd0:    begin c[j] = 1'b0; s[j] = 1'b0; end
        2'd1:    begin c[j] = alt[j]; s[j] = ~alt[j]; end
        default: begin c[j] = 1'b1; s[j] = 1'b1; end
      endcase
    end
    return {c, s};
  endfunction

  task automatic pushExp(input logic [W-1:0] ac, input logic [W-1:0] as_, input logic [W-1:0] bc,
                         input logic [W-1:0] bs, input bit m, input string tag);
    int va, vb;
    logic [W-1:0] ec, es;
    va = wordVal(ac, as_);
    vb = wordVal(bc, bs);
    qVal.push_back(m ? ((va < vb) ? va : vb) : ((va > vb) ? va : vb));
    qPick.push_back(m ? (vb < va) : (vb > va));
    qMin.push_back(m);
    qIdent.push_back((ac == bc) && (as_ == bs));
    for (int j = 0; j < W; j++) begin
      case (int'(ac[j]) + int'(as_[j]))
        0:       begin ec[j] = 1'b0; es[j] = 1'b0; end
        2:       begin ec[j] = 1'b1; es[j] = 1'b1; end
        default: begin ec[j] = m;    es[j] = ~m;   end
      endcase
    end
    qIdC.push_back(ec);
    qIdS.push_back(es);
    qTag.push_back(tag);
  endtask

  task automatic checkFront();
    int expV, actV;
    bit expP, m, id;
    logic [W-1:0] ic, is_, bad;
    string tag;
    expV = qVal.pop_front();
    expP = qPick.pop_front();
    m    = qMin.pop_front();
    id   = qIdent.pop_front();
    ic   = qIdC.pop_front();
    is_  = qIdS.pop_front();
    tag  = qTag.pop_front();
    actV = wordVal(gC, gS);
    compared++;
    if (actV !== expV) begin
      mismatched++;
      $display("FAIL %s value: actual %0d expected %0d", tag, actV, expV);
    end
    compared++;
    if (pickB !== expP) begin
      mismatched++;
      $display("FAIL R4 (%s) pickB: actual %0b expected %0b", tag, pickB, expP);
    end
    bad = m ? (~gC & gS) : (gC & ~gS);
    compared++;
    if (bad !== '0) begin
      mismatched++;
      $display("FAIL R5 digit form: actual mask %b expected %b", bad, {W{1'b0}});
    end
    if (id) begin
      compared++;
      if (gC !== ic || gS !== is_) begin
        mismatched++;
        $display("FAIL R6 identical digits: actual %b/%b expected %b/%b", gC, gS, ic, is_);
      end
    end
  endtask

  task automatic step(input logic [2*W-1:0] a, input logic [2*W-1:0] b, input bit m, input string tag);
    @(negedge clk);
    checkFront();
    aC = a[2*W-1:W]; aS = a[W-1:0];
    bC = b[2*W-1:W]; bS = b[W-1:0];
    selMin = m;
    pushExp(aC, aS, bC, bS, m, tag);
  endtask

  task automatic directedPair(input logic [2*W-1:0] va, input logic [2*W-1:0] vb, input string tag);
    for (int m = 0; m < 2; m++) begin
      step(enc(va, '0), enc(vb, '0), m[0], tag);
      step(enc(va, '1), enc(vb, '1), m[0], tag);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R7 watchdog: actual 200000 cycles expected completion earlier");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    logic [2*W-1:0] va, vb;
    logic [W-1:0] altA, altB;
    repeat (3) @(negedge clk);
    // R1: reset state
    compared++;
    if (gC !== '0 || gS !== '0 || pickB !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset outputs: actual %b/%b/%b expected 0/0/0", gC, gS, pickB);
    end
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < W; i++) pushExp('0, '0, '0, '0, 1'b0, "R1");

    // R8: MSB decides, lower digits of B cannot overturn
    directedPair({2'd2, {(W-1){2'd0}}}, {2'd0, {(W-1){2'd2}}}, "R8");
    directedPair({2'd0, {(W-1){2'd2}}}, {2'd2, {(W-1){2'd0}}}, "R8");
    // R10: tentative lead held to the LSB, won by one
    directedPair({2'd1, {(W-1){2'd0}}}, {2'd0, {(W-1){2'd1}}}, "R10");
    directedPair({2'd0, {(W-1){2'd1}}}, {2'd1, {(W-1){2'd0}}}, "R10");
    // R9: tentative lead cancelled, lower digits decide or tie
    directedPair({2'd1, {(W-1){2'd0}}}, {2'd0, {(W-2){2'd1}}, 2'd2}, "R9");
    directedPair({2'd1, {(W-1){2'd0}}}, {2'd0, 2'd2, {(W-3){2'd0}}, 2'd1}, "R9");
    directedPair({2'd0, 2'd2, {(W-3){2'd0}}, 2'd1}, {2'd1, {(W-1){2'd0}}}, "R9");
    // R2/R3 extremes
    directedPair({W{2'd2}}, {W{2'd0}}, "R2/R3");
    directedPair({W{2'd0}}, {W{2'd2}}, "R2/R3");
    // R6 identical words, R4 equal values with different codes
    directedPair({W{2'd1}}, {W{2'd1}}, "R6");
    for (int m = 0; m < 2; m++) step(enc({W{2'd1}}, '0), enc({W{2'd1}}, '1), m[0], "R4");

    // R7: back-to-back stream, mode changing freely
    for (int i = 0; i < 4000; i++) begin
      bit m;
      int kind;
      m = 1'($urandom);
      kind = int'($urandom % 7);
      for (int j = 0; j < W; j++) va[2*j +: 2] = 2'($urandom % 3);
      altA = W'($urandom);
      altB = W'($urandom);
      vb = va;
      if (kind < 4) begin
        for (int j = 0; j < W; j++) vb[2*j +: 2] = 2'($urandom % 3);
      end else if (kind == 4) begin
        altB = altA;
      end else if (kind == 6) begin
        int d;
        d = int'($urandom % W);
        vb[2*d +: 2] = 2'((int'(va[2*d +: 2]) + 1 + int'($urandom % 2)) % 3);
      end
      step(enc(va, altA), enc(vb, altB), m, m ? "R3/R7" : "R2/R7");
    end

    for (int i = 0; i < W; i++) step('0, '0, 1'b0, "R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule